// File: doc/BRIEF.md
# Shared-Counter Ramp Digitizer Back End

This block is the digital half of a single-slope converter. One analog ramp serves a large group of sample cells, and each cell has its own comparator. When a start pulse arrives, one common counter begins counting from zero on the fast conversion clock. Every cell watches its comparator. The first time that comparator goes high, the cell stores the count value of that moment as its conversion word. All cells are therefore digitized in parallel during a single sweep of the ramp.

The comparator outputs are asynchronous to the conversion clock, so they pass through a synchronizer before the edge detector sees them. The stored word is reduced by the synchronizer's fixed latency, so that it matches the count at which the comparator was first sampled high.

A sweep ends in one of two ways. Either the counter reaches full scale, or every cell has already stored a word. When the counter reaches full scale, any cell still waiting receives the all-ones word and its overflow flag is set. Results and the done flag then hold until the next start. The counter code can be plain binary or reflected Gray, chosen by a parameter.

Top module: `wk_conv`

## Requirements
- R1: After reset, done is low, every overflow flag is low and every result word is zero.
- R2: A start pulse clears every result word, every overflow flag and done at the clock edge that samples it. The shared counter is 0 after that edge and rises by one on each later edge.
- R3: A cell whose comparator is first sampled high while the counter shows k (k counter edges after the start edge) stores the value k. This holds for every k up to full scale minus SYNC_STAGES.
- R4: A cell stores a value only on the first rising edge of its comparator in a sweep. Later falls and rises of that comparator leave the stored word unchanged.
- R5: A comparator that is already high when start is sampled, or that rises close enough to start that the corrected count would be negative, yields the value 0.
- R6: When the counter reaches full scale (2^CNT_W-1), every cell that has not stored a value gets the all-ones binary value and its overflow flag set to 1. This includes cells whose comparator was first sampled in the last SYNC_STAGES counts.
- R7: If every cell stores a value before full scale, done rises one clock edge after the edge at which the last cell stored its value.
- R8: If some cell never fires, done rises on the edge 2^CNT_W edges after the start edge. It is low one edge earlier.
- R9: Done, the result words and the overflow flags hold while no start is given. Comparator activity outside a sweep has no effect on them.
- R10: With GRAY_OUT=1, each result word is the reflected Gray code (b xor (b >> 1)) of the binary value b defined by R3, R5 and R6. With GRAY_OUT=0, each result word is b itself.
- R11: Cells whose comparators are sampled high in the same cycle all store the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock; the shared counter advances on its rising edge |
| arst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle pulse that clears the results and begins a sweep |
| cmp_i | input | N_CELLS | Comparator output of each cell, asynchronous to the clock |
| result_o | output | N_CELLS*CNT_W | Result words; cell i occupies bits [i*CNT_W +: CNT_W] |
| ovf_o | output | N_CELLS | Per-cell flag showing the comparator never fired in time |
| done_o | output | 1 | High from the end of a sweep until the next start |

## Verification
The bench builds two copies of the block with 8 cells, an 8-bit counter and a two-stage synchronizer: one copy with binary output and one with Gray output. Both copies take the same stimulus. With a 256-count sweep, the full-scale ending is reachable in a few hundred cycles, and so is the boundary between the last count that can still be stored and the first one reported as overflow. Eight cells are enough to cover comparators firing at spread-out counts, all in the same cycle, before start, and not at all.

// File: rtl/wk_pkg.sv
package wk_pkg;

  // Sweep controller state
  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_RUN  = 2'd1,
    WK_HOLD = 2'd2
  } wk_state_e;

endpackage

// File: rtl/wk_rst_sync.sv
module wk_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [1:0] rst_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end

  assign rst_no = rst_q[1];

endmodule

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int unsigned WIDTH  = 256,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d_i;
    for (int s = 1; s < int'(STAGES); s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(STAGES); s++) begin
        stage_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < int'(STAGES); s++) begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/wk_ctrl.sv
module wk_ctrl
  import wk_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             all_fired_i,
  output logic             run_o,
  output logic             term_o,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  wk_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             run;
  logic             term;

  assign run  = (state_q == WK_RUN);
  assign term = run && (cnt_q == CNT_MAX);

  // Next state
  always_comb begin
    state_d = state_q;
    if (start_i) begin
      state_d = WK_RUN;
    end else if (run && (term || all_fired_i)) begin
      state_d = WK_HOLD;
    end
  end

  // Counter: restart on start, advance while sweeping below full scale
  assign cnt_en = start_i | (run & ~term);

  always_comb begin
    cnt_d = cnt_q;
    if (start_i) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WK_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign run_o   = run;
  assign term_o  = term;
  assign count_o = cnt_q;
  assign done_o  = (state_q == WK_HOLD);

endmodule

// File: rtl/wk_cell.sv
module wk_cell #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned LAT   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             term_i,
  input  logic             cmp_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] word_o,
  output logic             ovf_o,
  output logic             fired_o
);

  localparam logic [CNT_W-1:0] LAT_V   = CNT_W'(LAT);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             prev_q, prev_d;
  logic [CNT_W-1:0] word_q, word_d;
  logic             ovf_q, ovf_d;
  logic             fired_q, fired_d;
  logic             rise;
  logic             capture;
  logic             force_ovf;
  logic             upd_en;
  logic [CNT_W-1:0] corrected;

  // The previous level is cleared on start, so a comparator that is
  // already high counts as a rise at the start of the sweep
  assign prev_d    = start_i ? 1'b0 : cmp_i;
  assign rise      = cmp_i & ~prev_q;
  assign capture   = run_i & ~fired_q & rise;
  assign force_ovf = term_i & ~fired_q & ~rise;
  assign upd_en    = start_i | capture | force_ovf;

  // Take off the synchronizer latency; clamp at zero
  assign corrected = (count_i >= LAT_V) ? (count_i - LAT_V) : '0;

  always_comb begin
    word_d  = word_q;
    ovf_d   = ovf_q;
    fired_d = fired_q;
    if (start_i) begin
      word_d  = '0;
      ovf_d   = 1'b0;
      fired_d = 1'b0;
    end else if (capture) begin
      word_d  = corrected;
      fired_d = 1'b1;
    end else if (force_ovf) begin
      word_d  = CNT_MAX;
      ovf_d   = 1'b1;
      fired_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      word_q  <= '0;
      ovf_q   <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      if (upd_en) begin
        word_q  <= word_d;
        ovf_q   <= ovf_d;
        fired_q <= fired_d;
      end
    end
  end

  assign word_o  = word_q;
  assign ovf_o   = ovf_q;
  assign fired_o = fired_q;

endmodule

// File: rtl/wk_conv.sv
module wk_conv #(
  parameter int unsigned N_CELLS     = 256,
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          GRAY_OUT    = 1'b0
) (
  input  logic                       clk_i,
  input  logic                       arst_ni,
  input  logic                       start_i,
  input  logic [N_CELLS-1:0]         cmp_i,
  output logic [N_CELLS*CNT_W-1:0]   result_o,
  output logic [N_CELLS-1:0]         ovf_o,
  output logic                       done_o
);

  logic                rst_sync_n;
  logic [N_CELLS-1:0]  cmp_sync;
  logic [N_CELLS-1:0]  fired_w;
  logic [CNT_W-1:0]    word_w [N_CELLS];
  logic                run_w;
  logic                term_w;
  logic                all_fired_w;
  logic [CNT_W-1:0]    count_w;

  wk_rst_sync u_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_sync_n)
  );

  wk_sync #(
    .WIDTH  (N_CELLS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .d_i    (cmp_i),
    .q_o    (cmp_sync)
  );

  assign all_fired_w = &fired_w;

  wk_ctrl #(
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .start_i     (start_i),
    .all_fired_i (all_fired_w),
    .run_o       (run_w),
    .term_o      (term_w),
    .count_o     (count_w),
    .done_o      (done_o)
  );

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    wk_cell #(
      .CNT_W (CNT_W),
      .LAT   (SYNC_STAGES)
    ) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_sync_n),
      .start_i (start_i),
      .run_i   (run_w),
      .term_i  (term_w),
      .cmp_i   (cmp_sync[i]),
      .count_i (count_w),
      .word_o  (word_w[i]),
      .ovf_o   (ovf_o[i]),
      .fired_o (fired_w[i])
    );

    if (GRAY_OUT) begin : g_gray
      assign result_o[i*CNT_W +: CNT_W] = word_w[i] ^ (word_w[i] >> 1);
    end else begin : g_bin
      assign result_o[i*CNT_W +: CNT_W] = word_w[i];
    end
  end

endmodule

// File: rtl/wk_conv_chk.sv
module wk_conv_chk #(
  parameter int unsigned N    = 256,
  parameter int unsigned W    = 12,
  parameter bit          GRAY = 1'b0
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           done_i,
  input logic [N-1:0]   ovf_i,
  input logic [N*W-1:0] result_i,
  input logic           term_i,
  input logic           all_fired_i
);

  localparam logic [W-1:0] ALL1     = '1;
  localparam logic [W-1:0] OVF_WORD = GRAY ? (ALL1 ^ (ALL1 >> 1)) : ALL1;

  // R2: start wipes results, flags and done
  assert_clear_on_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_i && (ovf_i == '0) && (result_i == '0)));

  // R9: finished results are frozen until the next start
  assert_hold_after_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !start_i) |=> (done_i && $stable(result_i) && $stable(ovf_i)));

  // R6: an overflowed cell carries the full-scale word
  assert_ovf_word_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i[0] |-> (result_i[W-1:0] == OVF_WORD));

  // R7 and R8: done only follows full scale or every cell having fired
  assert_done_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $past(term_i || all_fired_i));

endmodule

bind wk_conv wk_conv_chk #(
  .N    (N_CELLS),
  .W    (CNT_W),
  .GRAY (GRAY_OUT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_sync_n),
  .start_i     (start_i),
  .done_i      (done_o),
  .ovf_i       (ovf_o),
  .result_i    (result_o),
  .term_i      (term_w),
  .all_fired_i (all_fired_w)
);

// File: tb/wk_conv_bench.sv
module wk_conv_bench;

  localparam int N  = 8;
  localparam int W  = 8;
  localparam int SS = 2;

  logic         clk = 1'b0;
  logic         arst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] cmp = '0;

  logic [N*W-1:0] res_b, res_g;
  logic [N-1:0]   ovf_b, ovf_g;
  logic           done_b, done_g;

  int n_chk = 0;
  int n_bad = 0;
  int k = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wk_conv #(.N_CELLS(N), .CNT_W(W), .SYNC_STAGES(SS), .GRAY_OUT(1'b0)) u_wk_conv (
    .clk_i(clk), .arst_ni(arst_n), .start_i(start), .cmp_i(cmp),
    .result_o(res_b), .ovf_o(ovf_b), .done_o(done_b));

  wk_conv #(.N_CELLS(N), .CNT_W(W), .SYNC_STAGES(SS), .GRAY_OUT(1'b1)) u_wk_conv_gray (
    .clk_i(clk), .arst_ni(arst_n), .start_i(start), .cmp_i(cmp),
    .result_o(res_g), .ovf_o(ovf_g), .done_o(done_g));

  function automatic logic [W-1:0] gr(input logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
    k += n;
  endtask

  task automatic adv_to(input int t);
    while (k < t) adv(1);
  endtask

  task automatic begin_run();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
  endtask

  task automatic quiet();
    cmp = '0;
    adv(4);
  endtask

  task automatic check_cell(input string req, input int i, input int val, input bit ovf);
    check({req, " bin word"}, 32'(res_b[i*W +: W]), 32'(val));
    check({req, " ovf flag"}, 32'(ovf_b[i]), 32'(ovf));
    check({"R10 gray word"}, 32'(res_g[i*W +: W]), 32'(gr(W'(val))));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // R1, R9: reset state, and idle comparator activity has no effect
  task automatic t_reset();
    check("R1 done", 32'(done_b), 0);
    check("R1 ovf", 32'(ovf_b), 0);
    check("R1 words", 32'(res_b), 0);
    cmp = 8'hA5;
    adv(5);
    cmp = 8'h3C;
    adv(5);
    check("R9 idle done", 32'(done_b), 0);
    check("R9 idle words", 32'(res_b), 0);
    check("R9 idle ovf", 32'(ovf_b), 0);
  endtask

  // R3, R4, R7: spread-out fire points, with cell 0 toggling after it fired
  task automatic t_spread();
    quiet();
    begin_run();
    for (int t = 0; t <= 52; t++) begin
      adv_to(t);
      for (int i = 0; i < N; i++) if (t == 3 + 7*i) cmp[i] = 1'b1;
      if (t == 6) cmp[0] = 1'b0;
      if (t == 9) cmp[0] = 1'b1;
    end
    adv_to(55);
    check("R7 done not yet", 32'(done_b), 0);
    adv_to(56);
    check("R7 done after last", 32'(done_b), 1);
    check("R7 gray copy done", 32'(done_g), 1);
    check_cell("R4 first edge only", 0, 3, 1'b0);
    for (int i = 1; i < N; i++) check_cell("R3 spread", i, 3 + 7*i, 1'b0);
  endtask

  // R11: all comparators in the same cycle
  task automatic t_same();
    quiet();
    begin_run();
    adv_to(20);
    cmp = '1;
    adv_to(23);
    check("R7 same done not yet", 32'(done_b), 0);
    adv_to(24);
    check("R7 same done", 32'(done_b), 1);
    for (int i = 0; i < N; i++) check_cell("R11 same cycle", i, 20, 1'b0);
  endtask

  // R5: comparator high before start and at the very first counts
  task automatic t_preset();
    quiet();
    cmp[2] = 1'b1;
    adv(4);
    begin_run();
    cmp[3] = 1'b1;
    adv_to(1);
    cmp[4] = 1'b1;
    adv_to(10);
    cmp = '1;
    adv_to(14);
    check("R7 preset done", 32'(done_b), 1);
    check_cell("R5 high before start", 2, 0, 1'b0);
    check_cell("R5 at count 0", 3, 0, 1'b0);
    check_cell("R3 at count 1", 4, 1, 1'b0);
    check_cell("R3 at count 10", 7, 10, 1'b0);
  endtask

  // R6, R8: full-scale ending and the last storable count
  task automatic t_overflow();
    quiet();
    begin_run();
    adv_to(253);
    cmp[0] = 1'b1;
    adv_to(254);
    cmp[1] = 1'b1;
    adv_to(255);
    check("R8 done one edge early", 32'(done_b), 0);
    adv_to(256);
    check("R8 done at full scale", 32'(done_b), 1);
    check_cell("R3 last storable", 0, 253, 1'b0);
    check_cell("R6 late fire", 1, 255, 1'b1);
    for (int i = 2; i < N; i++) check_cell("R6 never fired", i, 255, 1'b1);
  endtask

  // R9 then R2: hold after done, then clear on a new start
  task automatic t_hold();
    cmp = '0;
    adv(3);
    cmp = 8'h5A;
    adv(5);
    cmp = 8'h81;
    adv(3);
    check("R9 done held", 32'(done_b), 1);
    check_cell("R9 word held", 0, 253, 1'b0);
    check_cell("R9 ovf held", 1, 255, 1'b1);
    check("R9 ovf vector held", 32'(ovf_b), 32'hFE);
    cmp = '0;
    adv(4);
    begin_run();
    check("R2 done cleared", 32'(done_b), 0);
    check("R2 ovf cleared", 32'(ovf_b), 0);
    check("R2 words cleared", 32'(res_b), 0);
    check("R2 gray words cleared", 32'(res_g), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_spread();
    t_same();
    t_preset();
    t_overflow();
    t_hold();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule